// File: doc/BRIEF.md
# 64-bit Integer Execute Unit

This block carries out the integer register-register and register-immediate operations of a 64-bit load-store processor. Each issued operation supplies two 64-bit source values, a 16-bit immediate with a select that swaps it in for the second source, a destination register index and an operation code. One clock later the block returns the 64-bit result, the destination index and a write enable. It also returns an overflow trap flag for the signed arithmetic forms.

The operation set covers these groups:

- wrapping and overflow-checked addition and subtraction
- bitwise AND, OR and XOR
- the three shift kinds, with the shift amount taken from the immediate or from a register
- signed and unsigned less-than compares that produce 0 or 1
- a load of the immediate into the upper-middle bits of the result
- two conditional moves

The write enable is the single point where a register write is cancelled. This happens when a conditional move's test fails, when signed overflow traps, or when the destination is register 0, which must stay zero. The block holds one register stage and no other state.

Top module: `int_alu64`

## Requirements
- R1: Operation codes: 0 add-trapping, 1 add-wrapping, 2 sub-trapping, 3 sub-wrapping, 4 AND, 5 OR, 6 XOR, 7 shift-left, 8 shift-right-logical, 9 shift-right-arithmetic, 10 less-than-signed, 11 less-than-unsigned, 12 load-upper, 13 move-if-zero, 14 move-if-nonzero. For codes 0..3 the result is A plus or minus the second operand, modulo 2^64. The second operand is B, or the 16-bit immediate sign-extended to 64 bits when `use_imm` is 1.
- R2: For codes 0 and 2, `ovf_trap` is 1 exactly when the true signed result does not fit in 64 bits. The result still carries the wrapped value.
- R3: Codes 1 and 3 never raise `ovf_trap`.
- R4: Whenever `ovf_trap` is 1, `wr_en` is 0.
- R5: Codes 4..6 produce the bitwise AND, OR or XOR of A with the second operand, which is the sign-extended immediate when `use_imm` is 1.
- R6: Codes 7..9 shift A left, right with zero fill, or right with sign fill. The shift amount is `imm[5:0]` when `use_imm` is 1, and `opnd_b[5:0]` otherwise.
- R7: Codes 10 and 11 produce 1 when A is less than the second operand, and 0 otherwise. Code 10 compares as signed values and code 11 as unsigned values.
- R8: Code 12 places `imm` at result bits 47..32 and clears every other bit.
- R9: Codes 13 and 14 return A as the result. `wr_en` is 1 only when B is zero (code 13) or nonzero (code 14). `use_imm` has no effect on them.
- R10: When the destination index is 0, `wr_en` is 0 for every operation.
- R11: The outputs are registered. `out_valid` is 1 in the cycle after `in_valid` and 0 otherwise. While `out_valid` is 0, `wr_en` and `ovf_trap` are 0. After reset all outputs are 0. Code 15 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is issued this cycle |
| op | input | 4 | Operation code (see R1) |
| opnd_a | input | 64 | Source A |
| opnd_b | input | 64 | Source B |
| imm | input | 16 | Immediate field |
| use_imm | input | 1 | Use the sign-extended immediate in place of B |
| dest_idx | input | 5 | Destination register index |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Operation result |
| wr_en | output | 1 | Destination write permitted |
| ovf_trap | output | 1 | Signed overflow trap |
| out_dest | output | 5 | Destination index of the result |

## Verification
The only stored state is the single output register, so any fault in the datapath or in the write gating shows at the ports in the cycle after the operation is issued. A wrong carry or sign decision shows up as a mismatched result or a missing trap. A wrong enable decision lets a trapped or cancelled operation through, or lets register 0 be written. The stimulus mixes directed boundary values with random operations, so each of these paths is exercised under many operand patterns.

// File: rtl/alu64_pkg.sv
package alu64_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_SRA  = 4'd9,
        OP_SLT  = 4'd10,
        OP_SLTU = 4'd11,
        OP_LUI  = 4'd12,
        OP_MOVZ = 4'd13,
        OP_MOVN = 4'd14,
        OP_NONE = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_sel_e;
endpackage

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         lt_s,
    output logic         lt_u
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        lt_s  = sum[W-1] ^ ovf;
        lt_u  = ~wide[W];
    end
endmodule

// File: rtl/alu64_logic.sv
module alu64_logic
    import alu64_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu64_shift.sv
module alu64_shift
    import alu64_pkg::*;
#(
    parameter int W   = 64,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  logic [SHW-1:0] amt,
    input  shift_sel_e     sel,
    output logic [W-1:0]   y
);
    always_comb begin
        unique case (sel)
            SH_LEFT:  y = val << amt;
            SH_RIGHT: y = val >> amt;
            SH_ARITH: y = W'($signed(val) >>> amt);
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/int_alu64.sv
module int_alu64
    import alu64_pkg::*;
#(
    parameter int W       = 64,
    parameter int IMM_W   = 16,
    parameter int REG_W   = 5,
    parameter int LUI_POS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic [REG_W-1:0] dest_idx,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic             wr_en,
    output logic             ovf_trap,
    output logic [REG_W-1:0] out_dest
);
    localparam int SHW = $clog2(W);

    alu_op_e      op_e;
    logic [W-1:0] imm_sx;
    logic [W-1:0] opnd2;
    logic [SHW-1:0] sh_amt;
    logic [W-1:0] lui_val;
    logic         use_sub;
    logic [W-1:0] as_sum;
    logic         as_ovf, as_lt_s, as_lt_u;
    logic [W-1:0] lg_y, sh_y;
    logic_sel_e   lg_sel;
    shift_sel_e   sh_sel;

    logic [W-1:0] nxt_res;
    logic         nxt_cond;
    logic         nxt_trap;

    always_comb begin
        op_e    = alu_op_e'(op);
        imm_sx  = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
        opnd2   = use_imm ? imm_sx : opnd_b;
        sh_amt  = use_imm ? imm[SHW-1:0] : opnd_b[SHW-1:0];
        lui_val = '0;
        lui_val[LUI_POS +: IMM_W] = imm;
        use_sub = (op_e == OP_SUB) || (op_e == OP_SUBU) ||
                  (op_e == OP_SLT) || (op_e == OP_SLTU);
        unique case (op_e)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
        unique case (op_e)
            OP_SRL:  sh_sel = SH_RIGHT;
            OP_SRA:  sh_sel = SH_ARITH;
            default: sh_sel = SH_LEFT;
        endcase
    end

    alu64_addsub #(.W(W)) u_addsub (
        .a    (opnd_a),
        .b    (opnd2),
        .sub  (use_sub),
        .sum  (as_sum),
        .ovf  (as_ovf),
        .lt_s (as_lt_s),
        .lt_u (as_lt_u)
    );

    alu64_logic #(.W(W)) u_logic (
        .a   (opnd_a),
        .b   (opnd2),
        .sel (lg_sel),
        .y   (lg_y)
    );

    alu64_shift #(.W(W), .SHW(SHW)) u_shift (
        .val (opnd_a),
        .amt (sh_amt),
        .sel (sh_sel),
        .y   (sh_y)
    );

    always_comb begin
        nxt_res  = '0;
        nxt_cond = 1'b1;
        nxt_trap = 1'b0;
        unique case (op_e)
            OP_ADD, OP_SUB: begin
                nxt_res  = as_sum;
                nxt_trap = as_ovf;
            end
            OP_ADDU, OP_SUBU:        nxt_res = as_sum;
            OP_AND, OP_OR, OP_XOR:   nxt_res = lg_y;
            OP_SLL, OP_SRL, OP_SRA:  nxt_res = sh_y;
            OP_SLT:  nxt_res = {{(W-1){1'b0}}, as_lt_s};
            OP_SLTU: nxt_res = {{(W-1){1'b0}}, as_lt_u};
            OP_LUI:  nxt_res = lui_val;
            OP_MOVZ: begin
                nxt_res  = opnd_a;
                nxt_cond = (opnd_b == '0);
            end
            OP_MOVN: begin
                nxt_res  = opnd_a;
                nxt_cond = (opnd_b != '0);
            end
            default: nxt_cond = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            wr_en     <= 1'b0;
            ovf_trap  <= 1'b0;
            out_dest  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= nxt_res;
                out_dest <= dest_idx;
                ovf_trap <= nxt_trap;
                wr_en    <= nxt_cond && !nxt_trap && (dest_idx != '0);
            end else begin
                ovf_trap <= 1'b0;
                wr_en    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/int_alu64_chk.sv
module int_alu64_chk
    import alu64_pkg::*;
#(
    parameter int W     = 64,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       op,
    input logic [W-1:0]     opnd_b,
    input logic             out_valid,
    input logic [W-1:0]     result,
    input logic             wr_en,
    input logic             ovf_trap,
    input logic [REG_W-1:0] out_dest
);
    p_trap_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> !wr_en);

    p_zero_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dest == '0) |-> !wr_en);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_en && !ovf_trap));

    p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_ADDU || op == OP_SUBU)) |=> !ovf_trap);

    p_bool_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_SLT || op == OP_SLTU)) |=> (result[W-1:1] == '0));

    p_lui_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_LUI) |=> (result[31:0] == '0 && result[W-1:48] == '0));

    p_movz_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_MOVZ && opnd_b != '0) |=> !wr_en);

    p_movn_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_MOVN && opnd_b == '0) |=> !wr_en);
endmodule

bind int_alu64 int_alu64_chk #(.W(W), .REG_W(REG_W)) u_int_alu64_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opnd_b    (opnd_b),
    .out_valid (out_valid),
    .result    (result),
    .wr_en     (wr_en),
    .ovf_trap  (ovf_trap),
    .out_dest  (out_dest)
);

// File: tb/test_int_alu64.sv
`timescale 1ns/1ps
module test_int_alu64;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [15:0] imm = '0;
    logic        use_imm = 1'b0;
    logic [4:0]  dest_idx = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        wr_en;
    logic        ovf_trap;
    logic [4:0]  out_dest;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic        we;
        logic        trap;
        logic [4:0]  dest;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    int_alu64 i_int_alu64 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .use_imm(use_imm),
        .dest_idx(dest_idx), .out_valid(out_valid), .result(result),
        .wr_en(wr_en), .ovf_trap(ovf_trap), .out_dest(out_dest)
    );

    function automatic exp_t model(input logic [3:0] o, input logic [63:0] a,
                                   input logic [63:0] b, input logic [15:0] im,
                                   input logic ui, input logic [4:0] d);
        exp_t e;
        logic [63:0] b2;
        logic signed [64:0] w;
        logic [5:0] sa;
        logic cond;
        b2 = ui ? {{48{im[15]}}, im} : b;
        sa = ui ? im[5:0] : b[5:0];
        e.trap = 1'b0;
        cond = 1'b1;
        e.tag = "R1";
        case (o)
            4'd0, 4'd1: begin
                e.res = a + b2;
                w = $signed({a[63], a}) + $signed({b2[63], b2});
                if (o == 4'd0) e.trap = (w[64] != w[63]);
                e.tag = (o == 4'd0) ? "R2" : "R3";
            end
            4'd2, 4'd3: begin
                e.res = a - b2;
                w = $signed({a[63], a}) - $signed({b2[63], b2});
                if (o == 4'd2) e.trap = (w[64] != w[63]);
                e.tag = (o == 4'd2) ? "R2" : "R3";
            end
            4'd4: begin e.res = a & b2; e.tag = "R5"; end
            4'd5: begin e.res = a | b2; e.tag = "R5"; end
            4'd6: begin e.res = a ^ b2; e.tag = "R5"; end
            4'd7: begin e.res = a << sa; e.tag = "R6"; end
            4'd8: begin e.res = a >> sa; e.tag = "R6"; end
            4'd9: begin e.res = 64'($signed(a) >>> sa); e.tag = "R6"; end
            4'd10: begin e.res = ($signed(a) < $signed(b2)) ? 64'd1 : 64'd0; e.tag = "R7"; end
            4'd11: begin e.res = (a < b2) ? 64'd1 : 64'd0; e.tag = "R7"; end
            4'd12: begin e.res = {16'h0, im, 32'h0}; e.tag = "R8"; end
            4'd13: begin e.res = a; cond = (b == 0); e.tag = "R9"; end
            4'd14: begin e.res = a; cond = (b != 0); e.tag = "R9"; end
            default: begin e.res = 64'd0; cond = 1'b0; e.tag = "R11"; end
        endcase
        e.we = cond && !e.trap && (d != 0);
        e.dest = d;
        if (e.trap) e.tag = {e.tag, "/R4"};
        if (d == 0) e.tag = {e.tag, "/R10"};
        return e;
    endfunction

    task automatic issue(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                         input logic [15:0] im, input logic ui, input logic [4:0] d);
        @(negedge clk);
        in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b;
        imm = im; use_imm = ui; dest_idx = d;
        sb.push_back(model(o, a, b, im, ui, d));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: outputs registered at posedge, sampled mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #0.5;
            if (rst_n && out_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R11: out_valid=1 with nothing issued, expected out_valid=0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (result !== e.res || wr_en !== e.we || ovf_trap !== e.trap || out_dest !== e.dest) begin
                        errors++;
                        $display("FAIL %s: res=%h we=%b trap=%b dest=%0d expected res=%h we=%b trap=%b dest=%0d",
                                 e.tag, result, wr_en, ovf_trap, out_dest, e.res, e.we, e.trap, e.dest);
                    end
                end
            end else if (rst_n && (wr_en || ovf_trap)) begin
                checks++; errors++;
                $display("FAIL R11: idle cycle shows we=%b trap=%b, expected 0 and 0", wr_en, ovf_trap);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R11: watchdog expired, got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 64'd0 || wr_en !== 1'b0 || ovf_trap !== 1'b0) begin
            errors++;
            $display("FAIL R11: reset outputs v=%b res=%h we=%b trap=%b expected all 0",
                     out_valid, result, wr_en, ovf_trap);
        end
        rst_n = 1'b1;

        // R2: signed add and sub overflow both directions
        issue(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 1'b0, 5'd3);
        issue(4'd0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 1'b0, 5'd3);
        issue(4'd2, 64'h8000_0000_0000_0000, 64'd1, 16'h0, 1'b0, 5'd4);
        issue(4'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 1'b0, 5'd4);
        // R3: wrapping forms on the same operands
        issue(4'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 1'b0, 5'd5);
        issue(4'd3, 64'h8000_0000_0000_0000, 64'd1, 16'h0, 1'b0, 5'd5);
        // R1: immediate sign extension
        issue(4'd1, 64'd100, 64'd0, 16'hFFFF, 1'b1, 5'd6);
        issue(4'd0, 64'd5, 64'd999, 16'h7FFF, 1'b1, 5'd6);
        // R5 with immediate
        issue(4'd4, 64'hFFFF_0000_FFFF_0000, 64'd0, 16'h8F0F, 1'b1, 5'd7);
        issue(4'd6, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_0000_0000, 16'h0, 1'b0, 5'd7);
        // R6: shifts by 0 and 63, register amount uses low 6 bits only
        issue(4'd9, 64'h8000_0000_0000_0010, 64'd63, 16'h0, 1'b0, 5'd8);
        issue(4'd8, 64'h8000_0000_0000_0010, 64'hFFC0, 16'h0, 1'b0, 5'd8);
        issue(4'd7, 64'd1, 64'd0, 16'h003F, 1'b1, 5'd8);
        issue(4'd9, 64'h4000_0000_0000_0000, 64'd0, 16'hFFC4, 1'b1, 5'd8);
        // R7: signed vs unsigned on the same pair
        issue(4'd10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 1'b0, 5'd9);
        issue(4'd11, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 1'b0, 5'd9);
        issue(4'd10, 64'd3, 64'd0, 16'hFFFE, 1'b1, 5'd9);
        issue(4'd11, 64'd7, 64'd7, 16'h0, 1'b0, 5'd9);
        // R8
        issue(4'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'hABCD, 1'b1, 5'd10);
        // R9: both outcomes, use_imm ignored
        issue(4'd13, 64'hDEAD, 64'd0, 16'h1, 1'b1, 5'd11);
        issue(4'd13, 64'hDEAD, 64'd2, 16'h0, 1'b0, 5'd11);
        issue(4'd14, 64'hBEEF, 64'd0, 16'h5, 1'b1, 5'd11);
        issue(4'd14, 64'hBEEF, 64'h8000_0000_0000_0000, 16'h0, 1'b0, 5'd11);
        // R10
        issue(4'd1, 64'd1, 64'd2, 16'h0, 1'b0, 5'd0);
        issue(4'd13, 64'd9, 64'd0, 16'h0, 1'b0, 5'd0);
        // R11: unused code
        issue(4'd15, 64'd1, 64'd1, 16'h1, 1'b0, 5'd12);

        // back-to-back random stream with occasional idles
        for (int i = 0; i < 400; i++) begin
            logic [63:0] ra, rb;
            logic [3:0] ro;
            ra = {$urandom, $urandom};
            rb = ($urandom_range(0, 7) == 0) ? 64'd0 : {$urandom, $urandom};
            ro = 4'($urandom_range(0, 15));
            @(negedge clk);
            in_valid = 1'b1; op = ro; opnd_a = ra; opnd_b = rb;
            imm = 16'($urandom); use_imm = 1'($urandom); dest_idx = 5'($urandom);
            sb.push_back(model(op, opnd_a, opnd_b, imm, use_imm, dest_idx));
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R11: %0d results missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule